// File: doc/BRIEF.md
# Temperature Threshold Interrupt Controller

This block watches a stream of signed temperature samples and decides when to raise an interrupt. Each sample arrives with a one-cycle valid strobe. The block compares the sample against a programmable high limit and a lower hysteresis limit. It keeps a sticky interrupt status bit and drives an active-low, open-drain style alert line. The alert line is modelled as a pull-down enable: a 1 means the line is pulled low.

Three interrupt policies are available:
- **Default policy:** keeps re-raising the interrupt on every sample until the temperature falls below the hysteresis limit.
- **One-shot policy:** raises one interrupt on the way up and one on the way down.
- **Comparator policy:** makes the status bit follow the temperature relative to the high limit. A status read has no effect in this policy.

The surrounding logic supplies the limits, the policy select, an alert enable, a status-read strobe and a clear-alert strobe. The limits come from registers held elsewhere.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: While rst is 1 and on the first cycle after it, int_status is 0 and alert_pull is 0.
- R2: With mode 2'b00 (default policy), a valid sample strictly greater than hi_limit sets int_status at the next clock edge. A sample equal to hi_limit does not set it.
- R3: In the default policy, a sample above hi_limit makes the block "hot". While hot, every valid sample sets int_status again, even after a read. A valid sample strictly below hyst_limit ends the hot state, and later samples between the limits do not set int_status.
- R4: In the default and one-shot policies, status_rd clears int_status at the next edge. If status_rd and an interrupt-raising sample arrive in the same cycle, the read wins and int_status becomes 0.
- R5: With mode 2'b01 (one-shot policy), the first valid sample above hi_limit sets int_status once. Further samples do not set it again until a sample falls strictly below hyst_limit. That falling sample itself sets int_status and re-arms the block for the next sample above hi_limit.
- R6: With mode 2'b10 (comparator policy), a valid sample above hi_limit sets int_status. A sample below hi_limit clears it, and a sample equal to hi_limit leaves it unchanged. status_rd has no effect on int_status in this policy.
- R7: alert_pull is a registered output. It is 1 only when alert_en was 1, the new int_status is 1, and the alert is not masked.
- R8: A cycle with alert_clr at 1 masks the alert, so alert_pull is 0 at the next edge. int_status is unchanged. The mask lifts on the next valid sample that raises an interrupt.
- R9: All comparisons treat meas_temp, hi_limit and hyst_limit as signed two's-complement values.
- R10: Mode 2'b11 behaves as the default policy. A cycle without meas_valid never sets int_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | One-cycle strobe marking a new temperature sample |
| meas_temp | input | TEMP_W | Signed temperature sample |
| hi_limit | input | TEMP_W | Signed high limit |
| hyst_limit | input | TEMP_W | Signed hysteresis limit |
| mode | input | 2 | Interrupt policy: 00 default, 01 one-shot, 10 comparator, 11 default |
| alert_en | input | 1 | Enables the alert line |
| status_rd | input | 1 | Strobe: status register is being read |
| alert_clr | input | 1 | Strobe: release the alert line without touching status |
| int_status | output | 1 | Interrupt status bit |
| alert_pull | output | 1 | 1 pulls the active-low alert line low |

## Verification
Every result in this block appears exactly one clock edge after the inputs that cause it. Both int_status and alert_pull are registered, and alert_pull is computed from the same next-state values as the status bit, so the two change together.

The bench drives each cycle's inputs on the falling edge. It advances its own reference model for that cycle before the rising edge, then compares both outputs at the following falling edge. As a result, every check looks at the state one edge after its stimulus and never at a value in transition.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {
    MODE_DEFAULT     = 2'b00,
    MODE_ONESHOT     = 2'b01,
    MODE_COMPARE     = 2'b10,
    MODE_DEFAULT_ALT = 2'b11
  } tac_mode_e;

  typedef struct packed {
    logic above_hi;    // sample > high limit
    logic below_hi;    // sample < high limit
    logic below_hyst;  // sample < hysteresis limit
  } tac_cmp_t;
endpackage

// File: rtl/tac_compare.sv
module tac_compare #(
  parameter int TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] hi,
  input  logic [TEMP_W-1:0] hyst,
  output tac_pkg::tac_cmp_t res
);
  logic signed [TEMP_W-1:0] t_s, hi_s, hy_s;

  assign t_s  = $signed(temp);
  assign hi_s = $signed(hi);
  assign hy_s = $signed(hyst);

  always_comb begin
    res.above_hi   = t_s > hi_s;
    res.below_hi   = t_s < hi_s;
    res.below_hyst = t_s < hy_s;
  end
endmodule

// File: rtl/tac_event_fsm.sv
module tac_event_fsm (
  input  logic               clk,
  input  logic               rst,
  input  logic               meas_valid,
  input  tac_pkg::tac_mode_e mode,
  input  tac_pkg::tac_cmp_t  cmp,
  input  logic               status_rd,
  output logic               status_d,
  output logic               set_evt,
  output logic               status_q
);
  import tac_pkg::*;

  logic hot_q, hot_d;       // default policy: above-limit episode in progress
  logic wcold_q, wcold_d;   // one-shot policy: waiting for the falling crossing

  always_comb begin
    hot_d    = hot_q;
    wcold_d  = wcold_q;
    set_evt  = 1'b0;
    status_d = status_q;
    if (meas_valid) begin
      unique case (mode)
        MODE_COMPARE: begin
          if (cmp.above_hi) set_evt = 1'b1;
        end
        MODE_ONESHOT: begin
          if (!wcold_q && cmp.above_hi) begin
            set_evt = 1'b1;
            wcold_d = 1'b1;
          end else if (wcold_q && cmp.below_hyst) begin
            set_evt = 1'b1;
            wcold_d = 1'b0;
          end
        end
        default: begin
          if (cmp.above_hi)        hot_d = 1'b1;
          else if (cmp.below_hyst) hot_d = 1'b0;
          set_evt = hot_d;
        end
      endcase
    end
    if (mode == MODE_COMPARE) begin
      if (meas_valid) begin
        if (cmp.above_hi)      status_d = 1'b1;
        else if (cmp.below_hi) status_d = 1'b0;
      end
    end else if (status_rd) begin
      status_d = 1'b0;
    end else if (set_evt) begin
      status_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q    <= 1'b0;
      wcold_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      hot_q    <= hot_d;
      wcold_q  <= wcold_d;
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/tac_alert_out.sv
module tac_alert_out (
  input  logic clk,
  input  logic rst,
  input  logic alert_en,
  input  logic alert_clr,
  input  logic set_evt,
  input  logic status_d,
  output logic alert_pull
);
  logic mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (alert_clr)    mask_d = 1'b1;
    else if (set_evt) mask_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= 1'b0;
      alert_pull <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      alert_pull <= alert_en & status_d & ~mask_d;
    end
  end
endmodule

// File: rtl/temp_alarm_ctrl.sv
module temp_alarm_ctrl #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [TEMP_W-1:0] meas_temp,
  input  logic [TEMP_W-1:0] hi_limit,
  input  logic [TEMP_W-1:0] hyst_limit,
  input  logic [1:0]        mode,
  input  logic              alert_en,
  input  logic              status_rd,
  input  logic              alert_clr,
  output logic              int_status,
  output logic              alert_pull
);
  import tac_pkg::*;

  tac_mode_e mode_e;
  tac_cmp_t  cmp;
  logic      status_d, set_evt;

  assign mode_e = tac_mode_e'(mode);

  tac_compare #(.TEMP_W(TEMP_W)) u_cmp (
    .temp (meas_temp),
    .hi   (hi_limit),
    .hyst (hyst_limit),
    .res  (cmp)
  );

  tac_event_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .meas_valid (meas_valid),
    .mode       (mode_e),
    .cmp        (cmp),
    .status_rd  (status_rd),
    .status_d   (status_d),
    .set_evt    (set_evt),
    .status_q   (int_status)
  );

  tac_alert_out u_alert (
    .clk        (clk),
    .rst        (rst),
    .alert_en   (alert_en),
    .alert_clr  (alert_clr),
    .set_evt    (set_evt),
    .status_d   (status_d),
    .alert_pull (alert_pull)
  );
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              meas_valid,
  input logic [TEMP_W-1:0] meas_temp,
  input logic [TEMP_W-1:0] hi_limit,
  input logic [1:0]        mode,
  input logic              alert_en,
  input logic              status_rd,
  input logic              alert_clr,
  input logic              int_status,
  input logic              alert_pull
);
  logic above;
  assign above = $signed(meas_temp) > $signed(hi_limit);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!int_status && !alert_pull));

  // R4
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (status_rd && mode != 2'b10) |=> !int_status);

  // R6
  a_r6_read_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && status_rd && !meas_valid && int_status) |=> int_status);

  // R6
  a_r6_above_sets: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && meas_valid && above) |=> int_status);

  // R7
  a_r7_enable_gates: assert property (@(posedge clk) disable iff (rst)
    !alert_en |=> !alert_pull);

  // R8
  a_r8_clr_releases: assert property (@(posedge clk) disable iff (rst)
    alert_clr |=> !alert_pull);

  // R8
  a_r8_clr_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (alert_clr && !meas_valid && !status_rd) |=> $stable(int_status));

  // R10
  a_r10_no_sample_no_set: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |=> !$rose(int_status));
endmodule

bind temp_alarm_ctrl tac_checker #(.TEMP_W(TEMP_W)) u_tac_chk (
  .clk        (clk),
  .rst        (rst),
  .meas_valid (meas_valid),
  .meas_temp  (meas_temp),
  .hi_limit   (hi_limit),
  .mode       (mode),
  .alert_en   (alert_en),
  .status_rd  (status_rd),
  .alert_clr  (alert_clr),
  .int_status (int_status),
  .alert_pull (alert_pull)
);

// File: tb/tb_temp_alarm_ctrl.sv
`timescale 1ns/1ps
module tb_temp_alarm_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         meas_valid = 1'b0;
  logic [W-1:0] meas_temp = '0;
  logic [W-1:0] hi_limit = 8'd50;
  logic [W-1:0] hyst_limit = 8'd40;
  logic [1:0]   mode = 2'b00;
  logic         alert_en = 1'b1;
  logic         status_rd = 1'b0;
  logic         alert_clr = 1'b0;
  logic         int_status, alert_pull;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_st, m_hot, m_wc, m_mask, m_pull;

  always #2.5 clk = ~clk;

  temp_alarm_ctrl #(.TEMP_W(W)) dut (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_temp(meas_temp),
    .hi_limit(hi_limit), .hyst_limit(hyst_limit), .mode(mode),
    .alert_en(alert_en), .status_rd(status_rd), .alert_clr(alert_clr),
    .int_status(int_status), .alert_pull(alert_pull)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // Reference step, written from the requirements.
  task automatic model_step();
    bit set;
    int t, hi, hy;
    t = sx(meas_temp); hi = sx(hi_limit); hy = sx(hyst_limit);
    set = 0;
    if (meas_valid) begin
      if (mode == 2'b10) begin
        if (t > hi) set = 1;
      end else if (mode == 2'b01) begin
        if (!m_wc && t > hi) begin set = 1; m_wc = 1; end
        else if (m_wc && t < hy) begin set = 1; m_wc = 0; end
      end else begin
        if (t > hi) m_hot = 1;
        else if (t < hy) m_hot = 0;
        set = m_hot;
      end
    end
    if (mode == 2'b10) begin
      if (meas_valid && t > hi) m_st = 1;
      else if (meas_valid && t < hi) m_st = 0;
    end else if (status_rd) m_st = 0;
    else if (set) m_st = 1;
    if (alert_clr) m_mask = 1;
    else if (set) m_mask = 0;
    m_pull = alert_en & m_st & ~m_mask;
  endtask

  task automatic apply(input bit v, input int t, input bit rd, input bit clr);
    meas_valid = v; meas_temp = t[W-1:0]; status_rd = rd; alert_clr = clr;
    model_step();
    @(posedge clk); @(negedge clk);
    meas_valid = 0; status_rd = 0; alert_clr = 0;
  endtask

  task automatic do_reset(input logic [1:0] md);
    mode = md; rst = 1;
    meas_valid = 0; status_rd = 0; alert_clr = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
    m_st = 0; m_hot = 0; m_wc = 0; m_mask = 0; m_pull = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(2'b00);
    chk("R1", "status after reset", int_status, 1'b0);
    chk("R1", "alert after reset", alert_pull, 1'b0);

    // default policy, hi=50 hyst=40
    apply(1, 50, 0, 0); chk("R2", "equal no set", int_status, 1'b0);
    apply(1, 51, 0, 0); chk("R2", "above sets", int_status, 1'b1);
    chk("R7", "alert on", alert_pull, 1'b1);
    apply(0, 0, 1, 0);  chk("R4", "read clears", int_status, 1'b0);
    apply(1, 45, 0, 0); chk("R3", "re-raise while hot", int_status, 1'b1);
    apply(1, 39, 1, 0); chk("R3", "read with cold sample", int_status, 1'b0);
    apply(1, 45, 0, 0); chk("R3", "no re-raise after cold", int_status, 1'b0);
    apply(1, 60, 1, 0); chk("R4", "read beats set", int_status, 1'b0);

    // one-shot
    do_reset(2'b01);
    apply(1, 55, 0, 0); chk("R5", "first over", int_status, 1'b1);
    apply(0, 0, 1, 0);  chk("R5", "read clears", int_status, 1'b0);
    apply(1, 55, 0, 0); chk("R5", "no repeat", int_status, 1'b0);
    apply(1, 39, 0, 0); chk("R5", "falling interrupt", int_status, 1'b1);
    apply(0, 0, 1, 0);
    apply(1, 51, 0, 0); chk("R5", "re-armed", int_status, 1'b1);

    // comparator
    do_reset(2'b10);
    apply(1, 51, 0, 0); chk("R6", "above sets", int_status, 1'b1);
    apply(0, 0, 1, 0);  chk("R6", "read ignored", int_status, 1'b1);
    apply(1, 50, 0, 0); chk("R6", "equal holds", int_status, 1'b1);
    apply(1, 49, 0, 0); chk("R6", "below clears", int_status, 1'b0);
    apply(1, 70, 0, 0); chk("R8", "alert before clr", alert_pull, 1'b1);
    apply(0, 0, 0, 1);  chk("R8", "clr releases", alert_pull, 1'b0);
    chk("R8", "clr keeps status", int_status, 1'b1);
    apply(0, 0, 0, 0);  chk("R8", "mask held", alert_pull, 1'b0);
    apply(1, 70, 0, 0); chk("R8", "mask lifted", alert_pull, 1'b1);
    alert_en = 0;
    apply(0, 0, 0, 0);  chk("R7", "enable off", alert_pull, 1'b0);
    chk("R7", "status kept", int_status, 1'b1);
    alert_en = 1;

    // signed comparisons
    hi_limit = 8'd5; hyst_limit = 8'hF6; // 5 and -10
    do_reset(2'b00);
    apply(1, -5, 0, 0); chk("R9", "negative below limit", int_status, 1'b0);
    apply(1, 6, 0, 0);  chk("R9", "positive above", int_status, 1'b1);
    hi_limit = 8'd50; hyst_limit = 8'd40;

    // mode 11 and no-sample cycles
    do_reset(2'b11);
    apply(1, 51, 0, 0); chk("R10", "alt default sets", int_status, 1'b1);
    apply(0, 0, 1, 0);
    apply(1, 45, 0, 0); chk("R10", "alt default re-raise", int_status, 1'b1);
    apply(0, 0, 1, 0);
    apply(0, 100, 0, 0); chk("R10", "no sample no set", int_status, 1'b0);

    // constrained random, one policy per phase
    void'($urandom(32'd1234));
    for (int ph = 0; ph < 8; ph++) begin
      int hi, hy;
      hi = int'($urandom_range(80)) - 20;
      hy = hi - int'($urandom_range(10));
      hi_limit = hi[W-1:0]; hyst_limit = hy[W-1:0];
      do_reset(2'(ph % 4));
      for (int c = 0; c < 300; c++) begin
        int t;
        t = hi + int'($urandom_range(30)) - 15;
        alert_en = ($urandom_range(9) != 0);
        apply($urandom_range(2) != 0, t, $urandom_range(4) == 0, $urandom_range(9) == 0);
        chk(mode == 2'b10 ? "R6" : (mode == 2'b01 ? "R5" : "R3"), "random status", int_status, m_st);
        chk("R7", "random alert", alert_pull, m_pull);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule